// File: doc/BRIEF.md
# SIMD Lane Compare to Predicate Mask

The block compares two packed 512-bit operand vectors lane by lane and returns a 64-bit predicate mask, one mask bit for each 8-bit slice of the vector. A single opcode picks both the lane width and the relation. Integer relations cover equality, inequality, and signed and unsigned less-than and less-or-equal at 8-, 16- and 32-bit lanes. Floating-point relations cover half-precision and single-precision lanes. They work on the raw bit patterns with integer logic only. There is no rounding, no flag and no trap.

A lane that is 16 or 32 bits wide writes its single true/false answer into all of its 2 or 4 mask bits. Downstream predicated logic can then treat the mask at byte granularity whatever the element size. The result is registered: it is presented one clock after a valid request, together with an output strobe and an illegal-opcode flag.

Top module: `simd_pred_cmp`

## Requirements
- R1: The opcode is `{width[1:0], rel[3:0]}`, with width 0 = 8-bit lanes, 1 = 16-bit lanes and 2 = 32-bit lanes. Lane k of width W drives mask bits [k*W/8 +: W/8]. A true lane writes 0x1, 0x3 or 0xF into its field and a false lane writes zero.
- R2: rel 2 (lt) and rel 3 (le) are signed. Both operands have their lane MSB inverted, then an unsigned compare follows. For 16-bit lanes, 0x8000 lt 0x0001 is true (field 0x3).
- R3: rel 4 (ltu) and rel 5 (leu) compare raw unsigned values, so 0x8000 ltu 0x0001 is false. rel 0 (eq) and rel 1 (neq) compare bit patterns.
- R4: The ordered relations are rel 8 (oeq), rel 9 (olt) and rel 10 (ole). Each is false when either operand is NaN.
- R5: rel 11 (un) is true exactly when either operand is NaN. rel 12 (ueq), rel 13 (ult) and rel 14 (ule) are un OR the matching ordered relation.
- R6: An fp16 value is NaN when bits [14:10] are all ones and bits [9:0] are nonzero. An fp32 value is NaN when bits [30:23] are all ones and bits [22:0] are nonzero. Signalling and quiet NaNs are treated alike, and an infinity is not NaN.
- R7: +0 equals -0 under oeq, and neither is less than the other. oeq(+inf,+inf) is true, and olt(-inf,+inf) is true.
- R8: For floating-point less-than, a negative operand is below a positive one. Between two negative operands the larger magnitude is the smaller value.
- R9: in_valid produces out_valid exactly one cycle later, carrying that request's mask and illegal flag. Without in_valid, mask and illegal hold their values.
- R10: A floating-point rel (8 to 14) with width 0, width code 3, or rel 6, 7 or 15 yields an all-zero mask with illegal set. Every other opcode clears illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 6 | {width, rel} opcode |
| a | input | 512 | First operand vector |
| b | input | 512 | Second operand vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| mask | output | 64 | Predicate mask, one bit per 8-bit slice |
| illegal | output | 1 | Unsupported opcode flag |

## Verification
Every result is due on the clock edge right after the edge that captured its request, with exactly one register stage on the path. The driver applies each request on a falling edge and pushes the expected mask and flag into a queue. The monitor pops one entry on every falling edge where out_valid is high, half a period after the update. Idle stretches check that out_valid drops and that the mask holds over several cycles.

// File: rtl/simd_pred_cmp.sv
module simd_pred_cmp #(
  parameter int VEC_W = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [5:0]         op,
  input  logic [VEC_W-1:0]   a,
  input  logic [VEC_W-1:0]   b,
  output logic               out_valid,
  output logic [VEC_W/8-1:0] mask,
  output logic               illegal
);
  localparam int MW  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;

  function automatic logic int_rel(input logic [31:0] x, y, msb, input logic [2:0] rel);
    logic [31:0] xs, ys;
    xs = x ^ msb;
    ys = y ^ msb;
    case (rel)
      3'd0: int_rel = (x == y);
      3'd1: int_rel = (x != y);
      3'd2: int_rel = (xs < ys);
      3'd3: int_rel = (xs <= ys);
      3'd4: int_rel = (x < y);
      3'd5: int_rel = (x <= y);
      default: int_rel = 1'b0;
    endcase
  endfunction

  function automatic logic fp_rel(input logic [31:0] x, y, input logic dbl, input logic [2:0] rel);
    logic nx, ny, sx, sy, ord, eq, lt;
    logic [31:0] mx, my;
    nx = dbl ? (&x[30:23] && |x[22:0]) : (&x[14:10] && |x[9:0]);
    ny = dbl ? (&y[30:23] && |y[22:0]) : (&y[14:10] && |y[9:0]);
    sx = dbl ? x[31] : x[15];
    sy = dbl ? y[31] : y[15];
    mx = dbl ? {1'b0, x[30:0]} : {17'b0, x[14:0]};
    my = dbl ? {1'b0, y[30:0]} : {17'b0, y[14:0]};
    ord = !(nx || ny);
    eq  = (mx == 0 && my == 0) || (x == y);
    if (mx == 0 && my == 0) lt = 1'b0;
    else if (sx != sy)      lt = sx;
    else if (!sx)           lt = mx < my;
    else                    lt = mx > my;
    case (rel)
      3'd0: fp_rel = ord && eq;
      3'd1: fp_rel = ord && lt;
      3'd2: fp_rel = ord && (lt || eq);
      3'd3: fp_rel = !ord;
      3'd4: fp_rel = !ord || eq;
      3'd5: fp_rel = !ord || lt;
      3'd6: fp_rel = !ord || lt || eq;
      default: fp_rel = 1'b0;
    endcase
  endfunction

  wire [1:0] width = op[5:4];
  wire [3:0] rel   = op[3:0];
  wire       legal = (width != 2'd3) && (rel != 4'd6) && (rel != 4'd7) && (rel != 4'd15)
                     && !(rel[3] && width == 2'd0);

  logic [MW-1:0] m8, m16, m32, sel;

  for (genvar i = 0; i < MW; i++) begin : g_l8
    assign m8[i] = int_rel({24'b0, a[8*i +: 8]}, {24'b0, b[8*i +: 8]}, 32'h80, rel[2:0]);
  end

  for (genvar j = 0; j < N16; j++) begin : g_l16
    logic [31:0] x, y;
    logic        r;
    assign x = {16'b0, a[16*j +: 16]};
    assign y = {16'b0, b[16*j +: 16]};
    assign r = rel[3] ? fp_rel(x, y, 1'b0, rel[2:0]) : int_rel(x, y, 32'h8000, rel[2:0]);
    assign m16[2*j +: 2] = {2{r}};
  end

  for (genvar k = 0; k < N32; k++) begin : g_l32
    logic [31:0] x, y;
    logic        r;
    assign x = a[32*k +: 32];
    assign y = b[32*k +: 32];
    assign r = rel[3] ? fp_rel(x, y, 1'b1, rel[2:0]) : int_rel(x, y, 32'h8000_0000, rel[2:0]);
    assign m32[4*k +: 4] = {4{r}};
  end

  always_comb begin
    case (width)
      2'd0:    sel = m8;
      2'd1:    sel = m16;
      2'd2:    sel = m32;
      default: sel = '0;
    endcase
    if (!legal) sel = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mask      <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mask    <= sel;
        illegal <= !legal;
      end
    end
  end
endmodule

// File: rtl/simd_pred_cmp_checker.sv
module simd_pred_cmp_checker #(
  parameter int MW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [5:0]    op,
  input logic          out_valid,
  input logic [MW-1:0] mask,
  input logic          illegal
);
  localparam logic [MW-1:0] P2 = {MW/2{2'b01}};
  localparam logic [MW-1:0] P4 = {MW/4{4'b0001}};

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(mask) && $stable(illegal)));
  assert_zero_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> mask == '0);
  assert_fp_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[5:4] == 2'd0 && op[3]) |=> illegal);
  assert_field16_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[5:4] == 2'd1) |=> ((mask & P2) << 1) == (mask & ~P2));
  assert_field32_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[5:4] == 2'd2) |=>
      (((mask & P4) << 1) | ((mask & P4) << 2) | ((mask & P4) << 3) | (mask & P4)) == mask);
endmodule

bind simd_pred_cmp simd_pred_cmp_checker #(.MW(VEC_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .mask(mask), .illegal(illegal));

// File: tb/test_simd_pred_cmp.sv
module test_simd_pred_cmp;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [5:0] op = '0;
  logic [511:0] a = '0, b = '0;
  logic out_valid, illegal;
  logic [63:0] mask;

  typedef struct { logic [63:0] m; logic ill; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  localparam logic [63:0] ONES = '1;

  always #4 clk = ~clk;

  simd_pred_cmp i_simd_pred_cmp (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .mask(mask), .illegal(illegal));

  task automatic chk(input string tag, input logic [63:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input string tag, input logic [1:0] w, input logic [3:0] r,
                      input logic [511:0] x, y, input logic [63:0] m, input logic ill);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = {w, r}; a = x; b = y;
    e.m = m; e.ill = ill; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = ~a;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: unexpected out_valid, got 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, mask, e.m);
        chk({e.tag, " illegal R10"}, {63'b0, illegal}, {63'b0, e.ill});
      end
    end
  end

  function automatic logic [511:0] r16(input logic [15:0] v); return {32{v}}; endfunction
  function automatic logic [511:0] r32(input logic [31:0] v); return {16{v}}; endfunction
  function automatic logic [511:0] r8(input logic [7:0] v);   return {64{v}}; endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] va, vb;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk("reset R9 out_valid", {63'b0, out_valid}, 64'd0);
    chk("reset R9 mask", mask, 64'd0);
    chk("reset R10 illegal", {63'b0, illegal}, 64'd0);
    rst_n = 1'b1;

    send("R2 lt16 0x8000<1", 2'd1, 4'd2, r16(16'h8000), r16(16'h0001), ONES, 1'b0);
    send("R3 ltu16 0x8000<1", 2'd1, 4'd4, r16(16'h8000), r16(16'h0001), 64'd0, 1'b0);
    send("R2 le8 0x80<=0x7f", 2'd0, 4'd3, r8(8'h80), r8(8'h7f), ONES, 1'b0);
    send("R3 leu8 0xff<=1", 2'd0, 4'd5, r8(8'hff), r8(8'h01), 64'd0, 1'b0);
    send("R3 neq32 equal", 2'd2, 4'd1, r32(32'h1234_5678), r32(32'h1234_5678), 64'd0, 1'b0);
    for (int i = 0; i < 64; i++) begin va[8*i +: 8] = 8'(i); vb[8*i +: 8] = 8'd32; end
    send("R1 R3 ltu8 per lane", 2'd0, 4'd4, va, vb, 64'h0000_0000_FFFF_FFFF, 1'b0);
    for (int k = 0; k < 16; k++) begin va[32*k +: 32] = 32'd5; vb[32*k +: 32] = (k % 2 == 0) ? 32'd5 : 32'd6; end
    send("R1 R3 eq32 per lane", 2'd2, 4'd0, va, vb, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0);

    send("R4 oeq16 1,qnan", 2'd1, 4'd8, r16(16'h3c00), r16(16'h7e00), 64'd0, 1'b0);
    send("R4 olt16 1,1", 2'd1, 4'd9, r16(16'h3c00), r16(16'h3c00), 64'd0, 1'b0);
    send("R4 ole16 1,1", 2'd1, 4'd10, r16(16'h3c00), r16(16'h3c00), ONES, 1'b0);
    send("R5 un16 1,qnan", 2'd1, 4'd11, r16(16'h3c00), r16(16'h7e00), ONES, 1'b0);
    send("R5 ueq16 1,1", 2'd1, 4'd12, r16(16'h3c00), r16(16'h3c00), ONES, 1'b0);
    send("R5 ult16 1,qnan", 2'd1, 4'd13, r16(16'h3c00), r16(16'h7e00), ONES, 1'b0);
    send("R5 ule16 2,1", 2'd1, 4'd14, r16(16'h4000), r16(16'h3c00), 64'd0, 1'b0);
    send("R6 un16 snan", 2'd1, 4'd11, r16(16'h7c01), r16(16'h3c00), ONES, 1'b0);
    send("R6 un16 inf", 2'd1, 4'd11, r16(16'h7c00), r16(16'h3c00), 64'd0, 1'b0);
    send("R6 ole32 qnan", 2'd2, 4'd10, r32(32'h7fc0_0000), r32(32'h3f80_0000), 64'd0, 1'b0);
    send("R6 ule32 snan", 2'd2, 4'd14, r32(32'h7f80_0001), r32(32'h3f80_0000), ONES, 1'b0);

    send("R7 oeq16 +0,-0", 2'd1, 4'd8, r16(16'h0000), r16(16'h8000), ONES, 1'b0);
    send("R7 olt16 +0,-0", 2'd1, 4'd9, r16(16'h0000), r16(16'h8000), 64'd0, 1'b0);
    send("R7 oeq16 inf,inf", 2'd1, 4'd8, r16(16'h7c00), r16(16'h7c00), ONES, 1'b0);
    send("R7 olt16 -inf,+inf", 2'd1, 4'd9, r16(16'hfc00), r16(16'h7c00), ONES, 1'b0);
    send("R8 olt16 -2,-1", 2'd1, 4'd9, r16(16'hc000), r16(16'hbc00), ONES, 1'b0);
    send("R8 olt16 -1,-2", 2'd1, 4'd9, r16(16'hbc00), r16(16'hc000), 64'd0, 1'b0);
    send("R8 olt32 -2,1", 2'd2, 4'd9, r32(32'hc000_0000), r32(32'h3f80_0000), ONES, 1'b0);

    send("R10 fp on 8-bit lanes", 2'd0, 4'd8, r8(8'h01), r8(8'h01), 64'd0, 1'b1);
    send("R10 width code 3", 2'd3, 4'd0, r8(8'h01), r8(8'h01), 64'd0, 1'b1);
    send("R10 rel 6", 2'd1, 4'd6, r16(16'h0001), r16(16'h0002), 64'd0, 1'b1);
    send("R10 legal after illegal", 2'd0, 4'd0, r8(8'h07), r8(8'h07), ONES, 1'b0);
    idle(1);
    held = mask;
    idle(3);
    chk("R9 mask held while idle", mask, held);
    chk("R9 out_valid low while idle", {63'b0, out_valid}, 64'd0);
    chk("R9 queue drained", 64'(q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule